// File: doc/BRIEF.md
# Inbound Address Decode Window Bank

This block decides where an inbound bus access lands. Software programs six decode windows and one BAR through a small 32-bit register port. Each window holds three words. The control word packs a size mask, an attribute byte, a target identifier and an enable bit. The base word and the remap word keep only their upper 16 bits, so every window sits on a 64 KB boundary.

A purely combinational lookup port takes a 32-bit address. The BAR qualifies the address first: a disabled BAR, or an address outside the BAR, misses outright. A qualified address is compared against all windows in parallel. When several windows match, the lowest-numbered one wins. The port returns the target, the attribute, the winning index and a translated address. In the translated address the window-select bits are swapped for the remap value, unless the remap is zero.

Top module: `addr_win_bank`

## Requirements
- R1: After reset every register reads zero, and every lookup misses.
- R2: Register byte offsets follow a uniform 16-byte group per window w (0..5): control at 16*w, base at 16*w+0x4, remap at 16*w+0xC. BAR control is at 0x60 and BAR low base at 0x64. Every other offset reads zero and ignores writes.
- R3: Window control keeps size mask [31:16], attribute [15:8], target [7:4] and enable [0]. Bits [3:1] read back zero.
- R4: Window base, window remap and BAR low base keep only bits [31:16], and bits [15:0] read back zero. The BAR high base at 0x68 always reads zero and ignores writes. BAR control keeps [31:16] and [0].
- R5: Window w matches when it is enabled and (addr[31:16] & ~mask) equals (base & ~mask).
- R6: A lookup misses when BAR enable (bit 0 of 0x60) is clear, or when (addr[31:16] & ~barmask) differs from (barbase & ~barmask).
- R7: If several windows match, the lowest-numbered window is selected, and its index appears on lk_win.
- R8: On a hit, lk_target and lk_attr carry the selected window's target and attribute fields.
- R9: On a hit with a non-zero remap, lk_xaddr[31:16] = (remap & ~mask) | (addr[31:16] & mask), and lk_xaddr[15:0] = addr[15:0].
- R10: On a hit with a remap of zero, lk_xaddr equals the lookup address.
- R11: lk_miss is always the inverse of lk_hit. On a miss, lk_win, lk_target, lk_attr and lk_xaddr are all zero.
- R12: The lookup is combinational, and it reflects a register written on the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_addr | input | 32 | Address to look up |
| lk_hit | output | 1 | Address passed the BAR and matched a window |
| lk_miss | output | 1 | No target for this address |
| lk_win | output | 3 | Index of the selected window |
| lk_target | output | 4 | Target identifier of the selected window |
| lk_attr | output | 8 | Attribute byte of the selected window |
| lk_xaddr | output | 32 | Translated address |

## Verification
The bound checker evaluates several properties on every clock:
- hit and miss are exclusive, and a miss is quiet on all outputs;
- the untouched low half passes through on a hit;
- the selected index stays in range;
- the reserved register bits read as zero;
- the BAR high base reads as zero;
- a remap write reads back on the next cycle.

Three behaviours are shown only by the bench's scenarios, in which a behavioural model is compared against every output each cycle:
- lowest-index priority among overlapping windows;
- BAR gating by size mask and by enable;
- remap translation versus passthrough.

// File: rtl/win_pkg.sv
package win_pkg;
  localparam int ADDR_W     = 32;
  localparam int GRAN_W     = 16;
  localparam int HI_W       = ADDR_W - GRAN_W;
  localparam int NUM_WIN    = 6;
  localparam int IDX_W      = $clog2(NUM_WIN);
  localparam int REG_AW     = 8;
  localparam int TGT_W      = 4;
  localparam int ATTR_W     = 8;
  localparam int GRP_STRIDE = 16;
  localparam int CTRL_OFS   = 0;
  localparam int BASE_OFS   = 4;
  localparam int REMAP_OFS  = 12;
  localparam int LAST_GRP   = 'h50;
  localparam int BAR_CTRL   = 'h60;
  localparam int BAR_LO     = 'h64;
  localparam int BAR_HI     = 'h68;

  typedef struct packed {
    logic [HI_W-1:0]   mask;
    logic [ATTR_W-1:0] attr;
    logic [TGT_W-1:0]  tgt;
    logic              en;
    logic [HI_W-1:0]   base;
    logic [HI_W-1:0]   remap;
  } win_cfg_t;

  // group offset: strided windows, last one at its own fixed group
  function automatic int grp_base(int w, int n);
    return (w == n - 1) ? LAST_GRP : w * GRP_STRIDE;
  endfunction

  function automatic logic [ADDR_W-1:0] ctrl_word(win_cfg_t c);
    return {c.mask, c.attr, c.tgt, 3'b000, c.en};
  endfunction
endpackage

// File: rtl/win_regfile.sv
module win_regfile
  import win_pkg::*;
#(
  parameter int N_WIN = NUM_WIN,
  parameter int RA_W  = REG_AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [RA_W-1:0]          addr,
  input  logic [ADDR_W-1:0]        wdata,
  output logic [ADDR_W-1:0]        rdata,
  output win_cfg_t [N_WIN-1:0]     cfg,
  output logic [HI_W-1:0]          bar_mask,
  output logic [HI_W-1:0]          bar_base,
  output logic                     bar_en
);
  localparam logic [RA_W-1:0] A_BC = RA_W'(BAR_CTRL);
  localparam logic [RA_W-1:0] A_BL = RA_W'(BAR_LO);

  logic unused_bits;
  assign unused_bits = ^wdata[3:1];

  genvar w;
  generate
    for (w = 0; w < N_WIN; w++) begin : g_win
      localparam logic [RA_W-1:0] A_C = RA_W'(grp_base(w, N_WIN) + CTRL_OFS);
      localparam logic [RA_W-1:0] A_B = RA_W'(grp_base(w, N_WIN) + BASE_OFS);
      localparam logic [RA_W-1:0] A_R = RA_W'(grp_base(w, N_WIN) + REMAP_OFS);
      win_cfg_t cur, nxt;
      logic wr_c, wr_b, wr_r, ld;
      assign wr_c = we && (addr == A_C);
      assign wr_b = we && (addr == A_B);
      assign wr_r = we && (addr == A_R);
      assign ld   = wr_c | wr_b | wr_r;

      always_comb begin
        nxt = cur;
        if (wr_c) begin
          nxt.mask = wdata[ADDR_W-1:GRAN_W];
          nxt.attr = wdata[15:8];
          nxt.tgt  = wdata[7:4];
          nxt.en   = wdata[0];
        end
        if (wr_b) nxt.base  = wdata[ADDR_W-1:GRAN_W];
        if (wr_r) nxt.remap = wdata[ADDR_W-1:GRAN_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cur <= '0;
        else if (ld) cur <= nxt;
      end

      assign cfg[w] = cur;
    end
  endgenerate

  // BAR: control (mask + enable) and low base; high base is fixed zero
  logic            bc_ld, bl_ld;
  logic [HI_W-1:0] bmask_q, bmask_d, bbase_q, bbase_d;
  logic            ben_q, ben_d;

  assign bc_ld = we && (addr == A_BC);
  assign bl_ld = we && (addr == A_BL);

  always_comb begin
    bmask_d = bc_ld ? wdata[ADDR_W-1:GRAN_W] : bmask_q;
    ben_d   = bc_ld ? wdata[0] : ben_q;
    bbase_d = bl_ld ? wdata[ADDR_W-1:GRAN_W] : bbase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bmask_q <= '0;
      ben_q   <= 1'b0;
    end else if (bc_ld) begin
      bmask_q <= bmask_d;
      ben_q   <= ben_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bbase_q <= '0;
    else if (bl_ld) bbase_q <= bbase_d;
  end

  assign bar_mask = bmask_q;
  assign bar_base = bbase_q;
  assign bar_en   = ben_q;

  // read mux
  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_WIN; i++) begin
      if (addr == RA_W'(grp_base(i, N_WIN) + CTRL_OFS))  rdata = ctrl_word(cfg[i]);
      if (addr == RA_W'(grp_base(i, N_WIN) + BASE_OFS))  rdata = {cfg[i].base, {GRAN_W{1'b0}}};
      if (addr == RA_W'(grp_base(i, N_WIN) + REMAP_OFS)) rdata = {cfg[i].remap, {GRAN_W{1'b0}}};
    end
    if (addr == A_BC) rdata = {bmask_q, {(GRAN_W-1){1'b0}}, ben_q};
    if (addr == A_BL) rdata = {bbase_q, {GRAN_W{1'b0}}};
  end
endmodule

// File: rtl/win_match.sv
module win_match
  import win_pkg::*;
#(
  parameter int N_WIN = NUM_WIN
) (
  input  win_cfg_t [N_WIN-1:0] cfg,
  input  logic [HI_W-1:0]      addr_hi,
  output logic [N_WIN-1:0]     hit
);
  genvar w;
  generate
    for (w = 0; w < N_WIN; w++) begin : g_cmp
      assign hit[w] = cfg[w].en &&
                      ((addr_hi & ~cfg[w].mask) == (cfg[w].base & ~cfg[w].mask));
    end
  endgenerate
endmodule

// File: rtl/bar_gate.sv
module bar_gate
  import win_pkg::*;
(
  input  logic            en,
  input  logic [HI_W-1:0] mask,
  input  logic [HI_W-1:0] base,
  input  logic [HI_W-1:0] addr_hi,
  output logic            pass
);
  assign pass = en && ((addr_hi & ~mask) == (base & ~mask));
endmodule

// File: rtl/win_select.sv
module win_select
  import win_pkg::*;
#(
  parameter int N_WIN = NUM_WIN
) (
  input  win_cfg_t [N_WIN-1:0] cfg,
  input  logic [N_WIN-1:0]     hit_vec,
  input  logic                 pass,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic                 miss,
  output logic [IDX_W-1:0]     idx,
  output logic [TGT_W-1:0]     tgt,
  output logic [ATTR_W-1:0]    attr,
  output logic [ADDR_W-1:0]    xaddr
);
  logic            found;
  logic [IDX_W-1:0] sel;
  win_cfg_t        pick;
  logic [HI_W-1:0] xhi;

  // descending scan so the lowest matching index is the last assignment
  always_comb begin
    found = 1'b0;
    sel   = '0;
    pick  = '0;
    for (int w = N_WIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        found = 1'b1;
        sel   = IDX_W'(w);
        pick  = cfg[w];
      end
    end
  end

  assign xhi = (pick.remap & ~pick.mask) | (addr[ADDR_W-1:GRAN_W] & pick.mask);

  always_comb begin
    hit   = pass && found;
    miss  = !hit;
    idx   = '0;
    tgt   = '0;
    attr  = '0;
    xaddr = '0;
    if (hit) begin
      idx   = sel;
      tgt   = pick.tgt;
      attr  = pick.attr;
      xaddr = (pick.remap == '0) ? addr : {xhi, addr[GRAN_W-1:0]};
    end
  end
endmodule

// File: rtl/addr_win_bank.sv
module addr_win_bank
  import win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [IDX_W-1:0]  lk_win,
  output logic [TGT_W-1:0]  lk_target,
  output logic [ATTR_W-1:0] lk_attr,
  output logic [ADDR_W-1:0] lk_xaddr
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  win_cfg_t [NUM_WIN-1:0] cfg;
  logic [HI_W-1:0]        bar_mask, bar_base;
  logic                   bar_en, bar_pass;
  logic [NUM_WIN-1:0]     hit_vec;

  win_regfile #(.N_WIN(NUM_WIN), .RA_W(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg),
    .bar_mask(bar_mask), .bar_base(bar_base), .bar_en(bar_en)
  );

  bar_gate u_bar (
    .en(bar_en), .mask(bar_mask), .base(bar_base),
    .addr_hi(lk_addr[ADDR_W-1:GRAN_W]), .pass(bar_pass)
  );

  win_match #(.N_WIN(NUM_WIN)) u_match (
    .cfg(cfg), .addr_hi(lk_addr[ADDR_W-1:GRAN_W]), .hit(hit_vec)
  );

  win_select #(.N_WIN(NUM_WIN)) u_sel (
    .cfg(cfg), .hit_vec(hit_vec), .pass(bar_pass), .addr(lk_addr),
    .hit(lk_hit), .miss(lk_miss), .idx(lk_win), .tgt(lk_target),
    .attr(lk_attr), .xaddr(lk_xaddr)
  );
endmodule

// File: rtl/addr_win_bank_chk.sv
module addr_win_bank_chk
  import win_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic [ADDR_W-1:0] reg_rdata,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic [IDX_W-1:0]  lk_win,
  input logic [TGT_W-1:0]  lk_target,
  input logic [ATTR_W-1:0] lk_attr,
  input logic [ADDR_W-1:0] lk_xaddr
);
  localparam logic [REG_AW-1:0] WIN_END = REG_AW'(BAR_CTRL);
  localparam logic [REG_AW-1:0] HI_ADR  = REG_AW'(BAR_HI);

  p_hit_miss_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit != lk_miss);

  p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_target == '0 && lk_attr == '0 && lk_win == '0 && lk_xaddr == '0));

  p_low_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_xaddr[GRAN_W-1:0] == lk_addr[GRAN_W-1:0]));

  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (int'(lk_win) < NUM_WIN));

  p_ctrl_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < WIN_END && reg_addr[3:0] == 4'h0) |-> (reg_rdata[3:1] == 3'b000));

  p_base_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < WIN_END && reg_addr[3:0] == 4'h4) |-> (reg_rdata[GRAN_W-1:0] == '0));

  p_bar_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == HI_ADR) |-> (reg_rdata == '0));

  p_remap_rdback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_we) && reg_addr == $past(reg_addr) && reg_addr < WIN_END &&
     reg_addr[3:0] == 4'hC)
    |-> (reg_rdata == {$past(reg_wdata[ADDR_W-1:GRAN_W]), {GRAN_W{1'b0}}}));
endmodule

bind addr_win_bank addr_win_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_win(lk_win),
  .lk_target(lk_target), .lk_attr(lk_attr), .lk_xaddr(lk_xaddr)
);

// File: tb/addr_win_bank_tb.sv
module addr_win_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, lk_addr, lk_xaddr;
  logic        lk_hit, lk_miss;
  logic [2:0]  lk_win;
  logic [3:0]  lk_target;
  logic [7:0]  lk_attr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addr_win_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_win(lk_win),
    .lk_target(lk_target), .lk_attr(lk_attr), .lk_xaddr(lk_xaddr)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [0:255];

  function automatic logic [31:0] keep_mask(input logic [7:0] a);
    if (a < 8'h60) begin
      case (a[3:0])
        4'h0:    return 32'hFFFF_FFF1;
        4'h4:    return 32'hFFFF_0000;
        4'hC:    return 32'hFFFF_0000;
        default: return 32'h0;
      endcase
    end
    if (a == 8'h60) return 32'hFFFF_0001;
    if (a == 8'h64) return 32'hFFFF_0000;
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_reg[i] <= 32'h0;
    end else if (reg_we && keep_mask(reg_addr) != 0) begin
      m_reg[reg_addr] <= reg_wdata & keep_mask(reg_addr);
    end
  end

  function automatic void ref_look(input logic [31:0] a, output logic h,
                                   output logic [2:0] wi, output logic [3:0] t,
                                   output logic [7:0] at, output logic [31:0] x);
    logic [15:0] bm, cm, cb, rm;
    h = 0; wi = 0; t = 0; at = 0; x = 0;
    bm = m_reg[8'h60][31:16];
    if (!m_reg[8'h60][0]) return;
    if ((a[31:16] & ~bm) != (m_reg[8'h64][31:16] & ~bm)) return;
    for (int w = 0; w < 6; w++) begin
      cm = m_reg[16*w][31:16];
      cb = m_reg[16*w+4][31:16];
      rm = m_reg[16*w+12][31:16];
      if (m_reg[16*w][0] && ((a[31:16] & ~cm) == (cb & ~cm))) begin
        h = 1; wi = 3'(w); t = m_reg[16*w][7:4]; at = m_reg[16*w][15:8];
        x = (rm == 0) ? a : {(rm & ~cm) | (a[31:16] & cm), a[15:0]};
        return;
      end
    end
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle against the model
  always @(negedge clk) begin
    logic eh; logic [2:0] ew; logic [3:0] et; logic [7:0] ea; logic [31:0] ex;
    if (rst_n && !done) begin
      ref_look(lk_addr, eh, ew, et, ea, ex);
      chk("R5 hit", 32'(lk_hit), 32'(eh));
      chk("R11 miss", 32'(lk_miss), 32'(!eh));
      chk("R7 index", 32'(lk_win), 32'(ew));
      chk("R8 target", 32'(lk_target), 32'(et));
      chk("R8 attr", 32'(lk_attr), 32'(ea));
      chk("R9 xaddr", lk_xaddr, ex);
      chk("R2 rdata", reg_rdata, m_reg[reg_addr]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog R1..: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus helpers (start/end at posedge+1) ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic lkchk(input string req, input logic [31:0] a, input logic h,
                       input logic [2:0] w, input logic [3:0] t,
                       input logic [7:0] at, input logic [31:0] x);
    lk_addr = a;
    @(negedge clk);
    chk({req, " hit"}, 32'(lk_hit), 32'(h));
    chk({req, " win"}, 32'(lk_win), 32'(w));
    chk({req, " tgt"}, 32'(lk_target), 32'(t));
    chk({req, " attr"}, 32'(lk_attr), 32'(at));
    chk({req, " xaddr"}, lk_xaddr, x);
    @(posedge clk); #1;
  endtask

  initial begin
    logic [31:0] lfsr;
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; lk_addr = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    repeat (4) @(posedge clk); #1;

    // R1: reset state
    rdchk("R1 win0 ctrl", 8'h00, 32'h0);
    rdchk("R1 win5 ctrl", 8'h50, 32'h0);
    rdchk("R1 bar ctrl", 8'h60, 32'h0);
    lkchk("R1 lookup", 32'h1012_3456, 0, 0, 0, 0, 0);

    // BAR full range, window 0 = 16 MB at 0x1000_0000
    wr(8'h60, 32'hFFFF_0001);
    wr(8'h04, 32'h1000_0000);
    wr(8'h00, 32'h00FF_AB31);
    lkchk("R12 next-cycle", 32'h1012_3456, 1, 0, 4'h3, 8'hAB, 32'h1012_3456);
    lkchk("R10 zero remap", 32'h10FF_FFFF, 1, 0, 4'h3, 8'hAB, 32'h10FF_FFFF);
    lkchk("R5 outside", 32'h1100_0000, 0, 0, 0, 0, 0);

    // R9: remap
    wr(8'h0C, 32'h8000_1234);
    rdchk("R4 remap rdback", 8'h0C, 32'h8000_0000);
    lkchk("R9 remap", 32'h1012_3456, 1, 0, 4'h3, 8'hAB, 32'h8012_3456);

    // R7: overlapping window 2 (256 MB at 0x1000_0000)
    wr(8'h24, 32'h1000_0000);
    wr(8'h20, 32'h0FFF_5AC1);
    lkchk("R7 low wins", 32'h1012_3456, 1, 0, 4'h3, 8'hAB, 32'h8012_3456);
    lkchk("R8 win2", 32'h1800_0000, 1, 3'd2, 4'hC, 8'h5A, 32'h1800_0000);
    wr(8'h00, 32'h00FF_AB30);
    lkchk("R7 after disable", 32'h1012_3456, 1, 3'd2, 4'hC, 8'h5A, 32'h1012_3456);

    // window 5 in its own group
    wr(8'h54, 32'h2345_0000);
    wr(8'h5C, 32'h4000_0000);
    wr(8'h50, 32'h0000_77F1);
    lkchk("R9 win5", 32'h2345_ABCD, 1, 3'd5, 4'hF, 8'h77, 32'h4000_ABCD);

    // R3 / R4 / R2 register masking
    wr(8'h40, 32'h1234_FFFF);
    rdchk("R3 ctrl reserved", 8'h40, 32'h1234_FFF1);
    wr(8'h40, 32'h0);
    wr(8'h44, 32'hDEAD_BEEF);
    rdchk("R4 base low", 8'h44, 32'hDEAD_0000);
    wr(8'h68, 32'hFFFF_FFFF);
    rdchk("R4 bar high", 8'h68, 32'h0);
    wr(8'h6C, 32'hFFFF_FFFF);
    rdchk("R2 unmapped", 8'h6C, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    rdchk("R2 hole", 8'h08, 32'h0);

    // R6: BAR gating
    wr(8'h64, 32'h1000_0000);
    wr(8'h60, 32'h0FFF_0001);
    lkchk("R6 bar outside", 32'h2345_ABCD, 0, 0, 0, 0, 0);
    lkchk("R6 bar inside", 32'h1800_0000, 1, 3'd2, 4'hC, 8'h5A, 32'h1800_0000);
    wr(8'h60, 32'h0FFF_0000);
    lkchk("R6 bar off", 32'h1800_0000, 0, 0, 0, 0, 0);

    // pseudo-random sweep against the model (R5 R7 R8 R9)
    wr(8'h60, 32'hFFFF_0001);
    wr(8'h00, 32'h00FF_AB31);
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] == 4'h0) lk_addr = {16'h2345, lfsr[15:0]};
      else lk_addr = {3'b000, lfsr[4], lfsr[27:0]};
      reg_addr = {1'b0, lfsr[10:8], lfsr[6], 3'b000} | {4'h0, lfsr[12:11], 2'b00};
      @(posedge clk); #1;
    end

    // R1: mid-run reset clears everything
    rst_n = 0;
    @(posedge clk); #1;
    rst_n = 1;
    repeat (3) @(posedge clk); #1;
    rdchk("R1 after reset ctrl", 8'h20, 32'h0);
    rdchk("R1 after reset remap", 8'h5C, 32'h0);
    lkchk("R1 after reset lookup", 32'h1800_0000, 0, 0, 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule